// File: doc/BRIEF.md
# Endpoint FIFO Watermark Request Generator

This block raises the DMA service request for one endpoint FIFO. Software programs a 12-bit byte threshold through a 32-bit register port. The block compares that threshold with the FIFO occupancy on every clock. The quantity it compares depends on the endpoint direction. For a transmit endpoint it uses the number of bytes stored, and the request asks the DMA engine to fill the FIFO. For a receive endpoint it uses the number of free bytes, and the request asks the DMA engine to drain it.

The request has hysteresis. Once it is raised, it stays high until the compared quantity climbs to a release mark. The release mark is the FIFO depth minus a granularity allowance of four bytes per step of a 3-bit code. If the threshold already sits at or above the release mark, no hysteresis band exists and the request simply follows the low-level test. The FIFO storage and the DMA engine sit outside this block.

Top module: `ep_fifo_alarm`

## Requirements
- R1: A write with `wr_en_i` high loads `wr_data_i[11:0]` into the threshold on that clock edge, and `rd_data_o[11:0]` returns the stored threshold. The threshold has no reset value, and a write is accepted while reset is asserted.
- R2: `rd_data_o[31:12]` always reads zero, whatever was written to those bit positions.
- R3: In transmit mode (`dir_rx_i` = 0), the compared level is `fill_i`. The request rises on the clock edge after the level is at or below the threshold.
- R4: In receive mode (`dir_rx_i` = 1), the compared level is `depth_i - fill_i`, saturating at 0. The request rises on the clock edge after that free count is at or below the threshold.
- R5: The release mark is `depth_i - 4*gran_i`, saturating at 0. In transmit mode, a raised request drops on the clock edge after `fill_i` is at or above the mark.
- R6: In receive mode, a raised request drops on the clock edge after the free count is at or above the release mark.
- R7: While the threshold is below the release mark and the level stays below the mark, a raised request stays high, even when the level is above the threshold.
- R8: A threshold write affects comparisons from the clock edge after the write. A write does not drop a raised request unless the release condition holds.
- R9: When the threshold is at or above the release mark, the registered request equals the low-level test from the previous cycle, in both directions.
- R10: While `rst_ni` is low, `req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_rx_i | input | 1 | Endpoint direction: 0 transmit, 1 receive |
| fill_i | input | 12 | Bytes currently stored in the FIFO |
| depth_i | input | 12 | FIFO capacity in bytes |
| gran_i | input | 3 | Granularity code; the allowance is 4 bytes per step |
| wr_en_i | input | 1 | Threshold register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| req_o | output | 1 | Registered DMA service request |

## Verification
Assertions check four things on every cycle:
- the request rises only after the low-level test held;
- the request drops only after the level rose above the threshold, and only at the release mark or when no hysteresis band exists;
- a raised request stays high inside the band;
- a write is visible on readback one cycle later.

The bench scenarios show the remaining behaviour:
- the exact crossing points in both directions;
- saturation of the release mark when the granularity allowance exceeds the depth;
- a threshold moved in and out of the band while a request is raised;
- reserved bits held at zero after all-ones writes.

A cycle-accurate reference function checks these across a random walk of fill levels.

// File: rtl/fifo_alarm_pkg.sv
package fifo_alarm_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned THR_W     = 12;
  localparam int unsigned CNT_W     = 12;
  localparam int unsigned GRAN_W    = 3;
  localparam int unsigned GRAN_UNIT = 4;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } ep_dir_e;
endpackage

// File: rtl/alarm_thr_reg.sv
module alarm_thr_reg #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned THR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [THR_W-1:0] thr_o,
  output logic [REG_W-1:0] rd_data_o
);
  localparam int unsigned RSVD_W = REG_W - THR_W;

  logic [THR_W-1:0] thr_q;

  // threshold is deliberately left without reset
  always_ff @(posedge clk_i) begin
    if (wr_en_i) thr_q <= wr_data_i[THR_W-1:0];
  end

  assign thr_o     = thr_q;
  assign rd_data_o = {{RSVD_W{1'b0}}, thr_q};

  p_write_visible_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[THR_W-1:0] == $past(wr_data_i[THR_W-1:0])));

  p_hold_no_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(thr_o));
endmodule

// File: rtl/alarm_level_calc.sv
module alarm_level_calc #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned GRAN_W    = 3,
  parameter int unsigned GRAN_UNIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_rx_i,
  input  logic [CNT_W-1:0] fill_i,
  input  logic [CNT_W-1:0] depth_i,
  input  logic [GRAN_W-1:0] gran_i,
  output logic [CNT_W-1:0] level_o,
  output logic [CNT_W-1:0] mark_o
);
  import fifo_alarm_pkg::*;

  localparam int unsigned ALLOW_W = GRAN_W + $clog2(GRAN_UNIT) + 1;
  localparam int unsigned WIDE_W  = (ALLOW_W > CNT_W) ? ALLOW_W : CNT_W;

  logic [WIDE_W-1:0] allow_w;
  logic [WIDE_W-1:0] depth_w;
  logic [CNT_W-1:0]  free_c;

  assign allow_w = WIDE_W'(gran_i) * WIDE_W'(GRAN_UNIT);
  assign depth_w = WIDE_W'(depth_i);

  // free space, saturating if the fill count exceeds the depth
  assign free_c  = (fill_i > depth_i) ? '0 : (depth_i - fill_i);

  always_comb begin
    unique case (ep_dir_e'(dir_rx_i))
      DIR_RX:  level_o = free_c;
      default: level_o = fill_i;
    endcase
  end

  assign mark_o = (allow_w > depth_w) ? '0 : CNT_W'(depth_w - allow_w);

  p_mark_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o <= depth_i);

  p_rx_level_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_rx_i |-> (level_o <= depth_i));
endmodule

// File: rtl/alarm_hyst.sv
module alarm_hyst #(
  parameter int unsigned THR_W = 12,
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] thr_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [CNT_W-1:0] mark_i,
  output logic             req_o
);
  localparam int unsigned CMP_W = (THR_W > CNT_W) ? THR_W : CNT_W;

  logic [CMP_W-1:0] thr_w, lvl_w, mark_w;
  logic low_c, release_c, no_band_c, req_d, req_q;

  assign thr_w  = CMP_W'(thr_i);
  assign lvl_w  = CMP_W'(level_i);
  assign mark_w = CMP_W'(mark_i);

  assign low_c     = (lvl_w <= thr_w);
  assign release_c = (lvl_w >= mark_w);
  assign no_band_c = (thr_w >= mark_w);

  always_comb begin
    if (no_band_c || !req_q) req_d = low_c;
    else                     req_d = !release_c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  p_rise_on_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(low_c));

  p_fall_on_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(!low_c && (release_c || no_band_c)));

  p_hold_in_band_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !release_c && !no_band_c) |=> req_q);

  p_follow_no_band_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_band_c |=> (req_q == $past(low_c)));
endmodule

// File: rtl/ep_fifo_alarm.sv
module ep_fifo_alarm #(
  parameter int unsigned REG_W     = fifo_alarm_pkg::REG_W,
  parameter int unsigned THR_W     = fifo_alarm_pkg::THR_W,
  parameter int unsigned CNT_W     = fifo_alarm_pkg::CNT_W,
  parameter int unsigned GRAN_W    = fifo_alarm_pkg::GRAN_W,
  parameter int unsigned GRAN_UNIT = fifo_alarm_pkg::GRAN_UNIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_rx_i,
  input  logic [CNT_W-1:0]  fill_i,
  input  logic [CNT_W-1:0]  depth_i,
  input  logic [GRAN_W-1:0] gran_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              req_o
);
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] level, mark;

  alarm_thr_reg #(.REG_W(REG_W), .THR_W(THR_W)) u_thr (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .thr_o(thr), .rd_data_o
  );

  alarm_level_calc #(.CNT_W(CNT_W), .GRAN_W(GRAN_W), .GRAN_UNIT(GRAN_UNIT)) u_lvl (
    .clk_i, .rst_ni, .dir_rx_i, .fill_i, .depth_i, .gran_i,
    .level_o(level), .mark_o(mark)
  );

  alarm_hyst #(.THR_W(THR_W), .CNT_W(CNT_W)) u_hyst (
    .clk_i, .rst_ni, .thr_i(thr), .level_i(level), .mark_i(mark), .req_o
  );

  p_reset_idle_r10: assert property (@(posedge clk_i) !rst_ni |=> !req_o || rst_ni);
endmodule

// File: tb/tb_ep_fifo_alarm.sv
module tb_ep_fifo_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_rx = 1'b0;
  logic [11:0] fill = '0, depth = 12'd256;
  logic [2:0]  gran = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        req;

  int checks = 0, errors = 0, cycles = 0;
  int thr_m = 0;
  bit exp_prev = 0;

  always #10 clk = ~clk;

  ep_fifo_alarm dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_rx_i(dir_rx), .fill_i(fill), .depth_i(depth),
    .gran_i(gran), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data), .req_o(req)
  );

  function automatic bit model(bit prev, bit rx, int f, int d, int g, int t);
    int lvl, mark;
    lvl  = rx ? d - f : f;
    if (lvl < 0) lvl = 0;
    mark = d - 4 * g;
    if (mark < 0) mark = 0;
    if (t >= mark || !prev) return (lvl <= t);
    return !(lvl >= mark);
  endfunction

  task automatic chk(bit ok, string req_tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
    end
  endtask

  // drive one cycle after a negedge, then check at the next negedge
  task automatic step(bit rx, int f, int d, int g, bit wr, int wd, string tag, bit do_chk = 1);
    bit e;
    dir_rx = rx; fill = 12'(f); depth = 12'(d); gran = 3'(g);
    wr_en = wr; wr_data = 32'(wd);
    e = model(exp_prev, rx, f, d, g, thr_m);
    if (wr) thr_m = wd & 32'hFFF;
    @(negedge clk);
    wr_en = 1'b0;
    if (do_chk) chk(req == e, tag, int'(req), int'(e));
    exp_prev = e;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: write accepted during reset (threshold has no reset)
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'hFFFF_F020; thr_m = 32'h020;
    @(negedge clk);
    wr_en = 1'b0;
    chk(rd_data[11:0] == 12'h020, "R1", int'(rd_data[11:0]), 32);
    chk(rd_data[31:12] == '0, "R2", int'(rd_data[31:12]), 0);
    chk(req == 1'b0, "R10", int'(req), 0);
    fill = 12'd0; dir_rx = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R10", int'(req), 0);
    rst_n = 1'b1;

    // R3/R5/R7 transmit, depth 256, gran 2 -> mark 248, thr 32
    step(0, 100, 256, 2, 0, 0, "R3");
    step(0, 33, 256, 2, 0, 0, "R3");
    chk(req == 1'b0, "R3", int'(req), 0);
    step(0, 32, 256, 2, 0, 0, "R3");
    chk(req == 1'b1, "R3", int'(req), 1);
    step(0, 100, 256, 2, 0, 0, "R7");
    chk(req == 1'b1, "R7", int'(req), 1);
    step(0, 247, 256, 2, 0, 0, "R7");
    chk(req == 1'b1, "R7", int'(req), 1);
    step(0, 248, 256, 2, 0, 0, "R5");
    chk(req == 1'b0, "R5", int'(req), 0);
    step(0, 100, 256, 2, 0, 0, "R5");
    chk(req == 1'b0, "R5", int'(req), 0);

    // R8: write raises threshold; effective next cycle
    step(0, 100, 256, 2, 1, 150, "R8");
    chk(req == 1'b0, "R8", int'(req), 0);
    step(0, 100, 256, 2, 0, 0, "R8");
    chk(req == 1'b1, "R8", int'(req), 1);
    // lowering threshold does not drop a raised request
    step(0, 100, 256, 2, 1, 5, "R8");
    step(0, 100, 256, 2, 0, 0, "R8");
    chk(req == 1'b1, "R8", int'(req), 1);
    step(0, 250, 256, 2, 0, 0, "R8");
    chk(req == 1'b0, "R8", int'(req), 0);

    // R2: reserved bits ignore written ones
    step(0, 250, 256, 2, 1, 32'hFFFF_F010, "R2", 0);
    chk(rd_data == 32'h0000_0010, "R2", int'(rd_data), 16);

    // R4/R6 receive: free = depth - fill; thr 16, gran 0 -> mark 256
    step(1, 200, 256, 0, 0, 0, "R4");
    chk(req == 1'b0, "R4", int'(req), 0);
    step(1, 240, 256, 0, 0, 0, "R4");
    chk(req == 1'b1, "R4", int'(req), 1);
    step(1, 100, 256, 0, 0, 0, "R7");
    chk(req == 1'b1, "R7", int'(req), 1);
    step(1, 1, 256, 0, 0, 0, "R6");
    chk(req == 1'b1, "R6", int'(req), 1);
    step(1, 0, 256, 0, 0, 0, "R6");
    chk(req == 1'b0, "R6", int'(req), 0);

    // R9: threshold above mark -> no hysteresis
    step(0, 10, 64, 7, 1, 60, "R9", 0);   // mark 36, thr 60
    step(0, 50, 64, 7, 0, 0, "R9");
    chk(req == 1'b1, "R9", int'(req), 1);
    step(0, 61, 64, 7, 0, 0, "R9");
    chk(req == 1'b0, "R9", int'(req), 0);
    step(0, 60, 64, 7, 0, 0, "R9");
    chk(req == 1'b1, "R9", int'(req), 1);
    // R5 saturation: allowance 28 > depth 20 -> mark 0
    step(0, 20, 20, 7, 1, 0, "R5", 0);
    step(0, 0, 20, 7, 0, 0, "R5");
    chk(req == 1'b1, "R5", int'(req), 1);
    step(0, 1, 20, 7, 0, 0, "R5");
    chk(req == 1'b0, "R5", int'(req), 0);

    // random walk
    for (int seg = 0; seg < 20; seg++) begin
      int d, g, t, f;
      bit rx;
      d  = 32 + int'($urandom_range(0, 480));
      g  = int'($urandom_range(0, 7));
      t  = int'($urandom_range(0, d));
      rx = 1'($urandom_range(0, 1));
      f  = int'($urandom_range(0, d));
      step(rx, f, d, g, 1, t, "R1");
      chk(rd_data == 32'(t), "R1", int'(rd_data), t);
      for (int i = 0; i < 200; i++) begin
        f += int'($urandom_range(0, 16)) - 8;
        if (f < 0) f = 0;
        if (f > d) f = d;
        step(rx, f, d, g, 0, 0, rx ? "R6" : "R5");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule